// File: doc/BRIEF.md
# 8-bit ALU with Flag Register

This block is the arithmetic and logic core of an 8-bit processor datapath. It takes the accumulator, a second operand byte, the processor's current flag byte and a 4-bit operation select. It produces the result byte and a write-enable for that result in the same cycle. It also computes a new flag byte, which it captures in a flag register on the next clock edge when the operation is marked valid.

The flag byte has the layout S, Z, F5, H, F3, P/V, N, C from bit 7 down to bit 0. The block follows the exact rule each operation uses for the half-carry, for the choice between overflow and parity in P/V, and for the two undocumented copy bits F5 and F3. Decimal adjust, 16-bit arithmetic and operand addressing belong to other blocks.

The flag register has two states. It holds its value when `op_valid` is low. It loads the computed byte at the edge when `op_valid` is high. Reset clears it.

Top module: `alu8_flagunit`

## Requirements
- R1: Codes 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow: the result is `acc_in` plus or minus `opnd_in`, plus or minus `flags_in` bit 0 for codes 1 and 3. C is the carry or borrow out of bit 7. H is the carry or borrow out of bit 3. P/V is two's-complement overflow. N is 0 for adds and 1 for subtracts.
- R2: Codes 4 AND, 5 XOR, 6 OR: the result is the bitwise operation. H is 1 for AND and 0 for XOR and OR. N and C are 0. P/V is 1 when the result has an even number of ones.
- R3: Code 7 compare computes the subtract-code flags for `acc_in - opnd_in` with N=1 and does not write the result. F5 and F3 are bits 5 and 3 of `opnd_in`.
- R4: Unless stated otherwise, S is result bit 7, Z is 1 for a zero result, and F5 and F3 are result bits 5 and 3. The flag bits sit at S=7, Z=6, F5=5, H=4, F3=3, P/V=2, N=1, C=0.
- R5: Code 8 increments and code 9 decrements `opnd_in`. C keeps `flags_in` bit 0. P/V flags overflow (0x7F to 0x80, or 0x80 to 0x7F). H is the carry or borrow out of bit 3. N is 0 for increment and 1 for decrement.
- R6: Code 10 negates: the result is `0 - acc_in` with subtract-code flags and N=1.
- R7: Code 11 complements: the result is `~acc_in`. H=1 and N=1. F5 and F3 are taken from the result. S, Z, P/V and C are copied from `flags_in`.
- R8: Code 12 sets C=1 and clears H and N. Code 13 inverts C, loads H with the incoming C and clears N. Both take F5 and F3 from `acc_in` and copy S, Z and P/V from `flags_in`.
- R9: Codes 14 and 15 compute a flag byte equal to `flags_in` and do not write the result.
- R10: `result_we` is 1 for codes 0-6 and 8-11 and 0 otherwise. When it is 0, `result` equals `acc_in`.
- R11: `flags_q` resets to 0x00. It takes the computed flag byte at the clock edge where `op_valid` is 1 and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Load the computed flags at this edge |
| op_sel | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator |
| opnd_in | input | 8 | Second operand (the target of increment and decrement) |
| flags_in | input | 8 | Current flag byte |
| result | output | 8 | Result byte (combinational) |
| result_we | output | 1 | Result write-enable (combinational) |
| flags_q | output | 8 | Registered flag byte |

## Verification
The only state is the flag register. A wrong load or a missed hold shows on `flags_q` one clock after the operation that caused it. It then persists until the next valid operation. An error in the result or write-enable paths shows on the ports in the same cycle as the inputs.

The bench drives every operation over many operand pairs and both carry-in values. It compares the result and write-enable before the edge and `flags_q` after it. Each flag is checked against a behavioural integer model, so a single wrong bit, such as H or F5/F3 for compare, is caught on the first vector that exposes it.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_AND  = 4'd4,
        OP_XOR  = 4'd5,
        OP_OR   = 4'd6,
        OP_CP   = 4'd7,
        OP_INC  = 4'd8,
        OP_DEC  = 4'd9,
        OP_NEG  = 4'd10,
        OP_CPL  = 4'd11,
        OP_SCF  = 4'd12,
        OP_CCF  = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } alu_op_e;

    localparam int FL_C  = 0;
    localparam int FL_N  = 1;
    localparam int FL_PV = 2;
    localparam int FL_F3 = 3;
    localparam int FL_H  = 4;
    localparam int FL_F5 = 5;
    localparam int FL_Z  = 6;
    localparam int FL_S  = 7;

    // Build a flag byte whose S, Z, F5 and F3 follow the result byte
    function automatic logic [7:0] mk_flags(logic [7:0] r, logic h, logic pv,
                                            logic n, logic c);
        logic [7:0] f;
        f        = '0;
        f[FL_S]  = r[7];
        f[FL_Z]  = (r == 8'h00);
        f[FL_F5] = r[5];
        f[FL_H]  = h;
        f[FL_F3] = r[3];
        f[FL_PV] = pv;
        f[FL_N]  = n;
        f[FL_C]  = c;
        return f;
    endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  logic              cin,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic              hout,
    output logic              vout
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] y_eff;
    logic              c_eff;
    logic [DATA_W:0]   full;
    logic [HALF:0]     lo;

    // Subtraction as x + ~y + ~cin; carries inverted into borrows
    always_comb begin
        y_eff = sub ? ~y : y;
        c_eff = sub ? ~cin : cin;
        full  = {1'b0, x} + {1'b0, y_eff} + {{DATA_W{1'b0}}, c_eff};
        lo    = {1'b0, x[HALF-1:0]} + {1'b0, y_eff[HALF-1:0]} + {{HALF{1'b0}}, c_eff};
        sum   = full[DATA_W-1:0];
        cout  = full[DATA_W] ^ sub;
        hout  = lo[HALF] ^ sub;
        vout  = (x[DATA_W-1] == y_eff[DATA_W-1]) && (sum[DATA_W-1] != x[DATA_W-1]);
    end
endmodule

// File: rtl/alu8_step.sv
module alu8_step #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] x,
    input  logic              down,
    output logic [DATA_W-1:0] sum,
    output logic              hout,
    output logic              vout
);
    localparam int HALF = DATA_W / 2;
    localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    always_comb begin
        if (down) begin
            sum  = x - 1'b1;
            hout = (x[HALF-1:0] == '0);
            vout = (x == MIN_NEG);
        end else begin
            sum  = x + 1'b1;
            hout = (x[HALF-1:0] == '1);
            vout = (x == MAX_POS);
        end
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  logic [1:0]        sel,
    output logic [DATA_W-1:0] res,
    output logic              par_even
);
    always_comb begin
        unique case (sel)
            2'd0:    res = x & y;
            2'd1:    res = x ^ y;
            default: res = x | y;
        endcase
        par_even = ~^res;
    end
endmodule

// File: rtl/alu8_flagunit.sv
module alu8_flagunit
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_sel,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic [7:0]        flags_in,
    output logic [DATA_W-1:0] result,
    output logic              result_we,
    output logic [7:0]        flags_q
);
    alu_op_e           op;
    logic [DATA_W-1:0] ar_x, ar_y, ar_sum;
    logic              ar_cin, ar_sub, ar_c, ar_h, ar_v;
    logic [DATA_W-1:0] st_sum;
    logic              st_h, st_v;
    logic [DATA_W-1:0] lg_res;
    logic              lg_par;
    logic [7:0]        nf;

    assign op     = alu_op_e'(op_sel);
    assign ar_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CP) || (op == OP_NEG);
    assign ar_cin = ((op == OP_ADC) || (op == OP_SBC)) && flags_in[FL_C];
    assign ar_x   = (op == OP_NEG) ? '0 : acc_in;
    assign ar_y   = (op == OP_NEG) ? acc_in : opnd_in;

    alu8_addsub #(.DATA_W(DATA_W)) u_arith (
        .x(ar_x), .y(ar_y), .cin(ar_cin), .sub(ar_sub),
        .sum(ar_sum), .cout(ar_c), .hout(ar_h), .vout(ar_v)
    );

    alu8_step #(.DATA_W(DATA_W)) u_step (
        .x(opnd_in), .down(op == OP_DEC),
        .sum(st_sum), .hout(st_h), .vout(st_v)
    );

    alu8_logic #(.DATA_W(DATA_W)) u_logic (
        .x(acc_in), .y(opnd_in), .sel(op_sel[1:0]),
        .res(lg_res), .par_even(lg_par)
    );

    // Result, write-enable and next flag byte per operation
    always_comb begin
        nf        = flags_in;
        result    = acc_in;
        result_we = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
                result    = ar_sum;
                result_we = 1'b1;
                nf        = mk_flags(ar_sum, ar_h, ar_v, ar_sub, ar_c);
            end
            OP_CP: begin
                nf        = mk_flags(ar_sum, ar_h, ar_v, 1'b1, ar_c);
                nf[FL_F5] = opnd_in[5];
                nf[FL_F3] = opnd_in[3];
            end
            OP_AND, OP_XOR, OP_OR: begin
                result    = lg_res;
                result_we = 1'b1;
                nf        = mk_flags(lg_res, op == OP_AND, lg_par, 1'b0, 1'b0);
            end
            OP_INC, OP_DEC: begin
                result    = st_sum;
                result_we = 1'b1;
                nf        = mk_flags(st_sum, st_h, st_v, op == OP_DEC, flags_in[FL_C]);
            end
            OP_CPL: begin
                result    = ~acc_in;
                result_we = 1'b1;
                nf[FL_F5] = ~acc_in[5];
                nf[FL_F3] = ~acc_in[3];
                nf[FL_H]  = 1'b1;
                nf[FL_N]  = 1'b1;
            end
            OP_SCF: begin
                nf[FL_C]  = 1'b1;
                nf[FL_H]  = 1'b0;
                nf[FL_N]  = 1'b0;
                nf[FL_F5] = acc_in[5];
                nf[FL_F3] = acc_in[3];
            end
            OP_CCF: begin
                nf[FL_H]  = flags_in[FL_C];
                nf[FL_C]  = ~flags_in[FL_C];
                nf[FL_N]  = 1'b0;
                nf[FL_F5] = acc_in[5];
                nf[FL_F3] = acc_in[3];
            end
            OP_RSV0, OP_RSV1: begin
                nf = flags_in;
            end
        endcase
    end

    // Flag register: HOLD when op_valid is low, LOAD when high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (op_valid) begin
            flags_q <= nf;
        end
    end

    AST_SCF_SETS_C: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_SCF) |=> (flags_q[FL_C] && !flags_q[FL_N])); // R8
    AST_CCF_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_CCF) |=> ((flags_q[FL_H] == $past(flags_in[FL_C]))
                                             && (flags_q[FL_C] != $past(flags_in[FL_C])))); // R8
    AST_LOGIC_NC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_sel == OP_AND || op_sel == OP_XOR || op_sel == OP_OR))
        |=> (!flags_q[FL_C] && !flags_q[FL_N])); // R2
    AST_STEP_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_sel == OP_INC || op_sel == OP_DEC))
        |=> (flags_q[FL_C] == $past(flags_in[FL_C]))); // R5
    AST_CP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_CP) |-> (!result_we && result == acc_in)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(flags_q)); // R11
endmodule

// File: tb/alu8_flagunit_tb_top.sv
`timescale 1ns/1ps
module alu8_flagunit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_sel = '0;
    logic [7:0] acc_in = '0;
    logic [7:0] opnd_in = '0;
    logic [7:0] flags_in = '0;
    logic [7:0] result;
    logic       result_we;
    logic [7:0] flags_q;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;   // 250 MHz

    alu8_flagunit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .acc_in(acc_in), .opnd_in(opnd_in), .flags_in(flags_in),
        .result(result), .result_we(result_we), .flags_q(flags_q)
    );

    function automatic int sx(int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    function automatic int ones(int v);
        int k = 0;
        for (int i = 0; i < 8; i++) k += (v >> i) & 1;
        return k;
    endfunction

    function automatic string tag_of(int op);
        if (op <= 3)  return "R1 R4";
        if (op <= 6)  return "R2 R4";
        if (op == 7)  return "R3";
        if (op <= 9)  return "R5 R4";
        if (op == 10) return "R6 R4";
        if (op == 11) return "R7";
        if (op <= 13) return "R8";
        return "R9";
    endfunction

    // Behavioural model: returns {we, result, flags}
    function automatic logic [16:0] ref_model(int op, int a, int b, int f);
        int r = a, we = 0, s, z, f5, h, f3, pv, n, c, sr, cin;
        s = (f >> 7) & 1; z = (f >> 6) & 1; f5 = (f >> 5) & 1; h = (f >> 4) & 1;
        f3 = (f >> 3) & 1; pv = (f >> 2) & 1; n = (f >> 1) & 1; c = f & 1;
        if (op <= 3 || op == 7 || op == 10) begin
            int x = (op == 10) ? 0 : a;
            int y = (op == 10) ? a : b;
            cin = (op == 1 || op == 3) ? (f & 1) : 0;
            if (op <= 1) begin
                r = x + y + cin; c = (r > 255);
                h = (((x & 15) + (y & 15) + cin) > 15); sr = sx(x) + sx(y) + cin; n = 0;
            end else begin
                r = x - y - cin; c = (r < 0);
                h = (((x & 15) - (y & 15) - cin) < 0); sr = sx(x) - sx(y) - cin; n = 1;
            end
            r = r & 255; pv = (sr > 127 || sr < -128);
            s = r >> 7; z = (r == 0); f5 = (r >> 5) & 1; f3 = (r >> 3) & 1;
            if (op == 7) begin
                f5 = (b >> 5) & 1; f3 = (b >> 3) & 1; r = a;
            end else we = 1;
        end else if (op <= 6) begin
            r = (op == 4) ? (a & b) : (op == 5) ? (a ^ b) : (a | b);
            we = 1; h = (op == 4); n = 0; c = 0; pv = (ones(r) % 2 == 0);
            s = r >> 7; z = (r == 0); f5 = (r >> 5) & 1; f3 = (r >> 3) & 1;
        end else if (op == 8 || op == 9) begin
            we = 1;
            if (op == 8) begin r = (b + 1) & 255; h = ((b & 15) == 15); pv = (b == 127); n = 0; end
            else begin r = (b + 255) & 255; h = ((b & 15) == 0); pv = (b == 128); n = 1; end
            s = r >> 7; z = (r == 0); f5 = (r >> 5) & 1; f3 = (r >> 3) & 1;
        end else if (op == 11) begin
            we = 1; r = 255 - a; h = 1; n = 1; f5 = (r >> 5) & 1; f3 = (r >> 3) & 1;
        end else if (op == 12) begin
            c = 1; h = 0; n = 0; f5 = (a >> 5) & 1; f3 = (a >> 3) & 1;
        end else if (op == 13) begin
            h = c; c = 1 - c; n = 0; f5 = (a >> 5) & 1; f3 = (a >> 3) & 1;
        end
        return {we[0], r[7:0], s[0], z[0], f5[0], h[0], f3[0], pv[0], n[0], c[0]};
    endfunction

    // R10, R11: result/we checked before the edge, flags after it
    task automatic run_vec(int op, int a, int b, int f);
        logic [16:0] e;
        bit bad = 0;
        @(negedge clk);
        op_sel = op[3:0]; acc_in = a[7:0]; opnd_in = b[7:0]; flags_in = f[7:0]; op_valid = 1'b1;
        e = ref_model(op, a, b, f);
        #1;
        if (result_we !== e[16] || result !== e[15:8]) begin
            bad = 1;
            $display("FAIL %s R10 op=%0d a=%h b=%h f=%h: we/res actual=%b/%h expected=%b/%h",
                     tag_of(op), op, a[7:0], b[7:0], f[7:0], result_we, result, e[16], e[15:8]);
        end
        @(posedge clk); #1;
        if (flags_q !== e[7:0]) begin
            bad = 1;
            $display("FAIL %s R11 op=%0d a=%h b=%h f=%h: flags actual=%b expected=%b",
                     tag_of(op), op, a[7:0], b[7:0], f[7:0], flags_q, e[7:0]);
        end
        n_vec++;
        if (bad) n_fail++;
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            $display("FAIL watchdog R11: actual=hung expected=finished");
            n_fail++;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        int alist[20];
        logic [7:0] held;
        for (int i = 0; i < 16; i++) alist[i] = i * 17;
        alist[16] = 8'h7F; alist[17] = 8'h80; alist[18] = 8'h0F; alist[19] = 8'h10;

        // R11: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (flags_q !== 8'h00) begin
            n_fail++;
            $display("FAIL R11 reset: actual=%h expected=00", flags_q);
        end
        rst_n = 1'b1;

        // R1 R2 R3: binary ops over operand sweeps and both carry-ins
        for (int op = 0; op < 8; op++)
            for (int ai = 0; ai < 20; ai++)
                for (int b = 0; b < 256; b++)
                    for (int ci = 0; ci < 2; ci++)
                        run_vec(op, alist[ai], b, ((alist[ai] * 7 + b * 13) & 8'hFE) | ci);

        // R5 R6 R7 R8 R9: unary, flag-only and reserved codes
        for (int op = 8; op < 16; op++)
            for (int x = 0; x < 256; x++)
                for (int ci = 0; ci < 2; ci++)
                    run_vec(op, x, x ^ 8'h5A, ((x * 37) & 8'hFE) | ci);

        // R11: hold while op_valid is low
        run_vec(12, 8'h28, 0, 8'h00);
        held = flags_q;
        @(negedge clk);
        op_valid = 1'b0; op_sel = 4'd13; flags_in = 8'h00; acc_in = 8'hFF;
        @(posedge clk); #1;
        n_vec++;
        if (flags_q !== held) begin
            n_fail++;
            $display("FAIL R11 hold: actual=%h expected=%h", flags_q, held);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule